// File: doc/BRIEF.md
# Peripheral Slot Strobe Timing Generator

This block drives access strobes toward as many as four slow peripherals that share a local bus. Each peripheral sits in a numbered slot. Every slot has two timings of its own: how long its strobe stays high, and how long the bus must then stay quiet before another access can begin. Each timing is picked by a 2-bit code from a short, non-linear list of clock counts. A single 16-bit timing word holds the codes for all slots, and a host loads it through a plain write port.

A requester presents a slot number and a read/write flag. The block then runs one access to completion. It raises that slot's strobe for the programmed duration, waits out the recovery interval with every strobe low, and finally pulses done. On reads it captures the peripheral's data on the last strobe clock. Requests that arrive while an access is running are ignored. Timing writes take effect only while the block is idle.

Top module: `slot_strobe_gen`

## Requirements
- R1: A 2-bit timing code selects a count of bus clocks: code 00 gives 3, code 01 gives 4, code 10 gives 12 and code 11 gives 15.
- R2: Slot s owns bits [4s+3:4s] of the timing word. Within that field, bits [4s+3:4s+2] are the duration code and bits [4s+1:4s] are the recovery code.
- R3: After reset the timing word is all zeros, so every slot uses 3 clocks of duration and 3 clocks of recovery. Before the first request, strobe_o, busy_o, done_o and rd_data_o are all zero.
- R4: An accepted request raises exactly one strobe bit, strobe_o[slot], starting in the cycle after acceptance and lasting exactly the duration count. During those cycles strobe_we_o equals the request's write flag (1 = write).
- R5: Recovery starts on the first clock after the strobe drops. It lasts exactly the recovery count, with busy_o high and all strobes low.
- R6: done_o is a one-cycle pulse in the cycle that follows the last recovery clock. busy_o is low in that cycle, and a request presented in that cycle is accepted.
- R7: busy_o is high from the cycle after acceptance through the last recovery clock.
- R8: A request presented while busy_o is high is dropped: it never produces a strobe, even after the running access finishes.
- R9: For a read, rd_data_o takes the value of rd_data_i sampled on the last duration clock. A write leaves rd_data_o unchanged.
- R10: A timing-word write made while busy_o is high is ignored. A write made while idle applies to the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Timing word write enable |
| cfg_wdata_i | input | 16 | Timing word value, four 4-bit slot fields |
| req_i | input | 1 | Access request |
| req_slot_i | input | 2 | Slot number of the request |
| req_we_i | input | 1 | 1 = write access, 0 = read access |
| rd_data_i | input | 8 | Data returned by the peripheral |
| busy_o | output | 1 | Access in progress (strobe or recovery) |
| done_o | output | 1 | One-cycle pulse after recovery ends |
| strobe_o | output | 4 | One strobe per slot, at most one high |
| strobe_we_o | output | 1 | Write flag, valid while a strobe is high |
| rd_data_o | output | 8 | Data captured on the last read strobe clock |

## Verification
The vector table loads two timing words whose four slot fields together cover every duration code and every recovery code, with the two codes of a field always different. This shows whether duration and recovery are decoded from the correct half of the correct field. Each access is run on a different slot with reads and writes mixed. The bench drives rd_data_i with the running strobe count, so the captured value shows the exact clock on which data was sampled. Directed cases cover these points:
- the reset defaults;
- a timing write made while busy, followed by one made while idle;
- a request held during a long access;
- two accesses back to back, with the second request presented in the done cycle.

These separate a dropped request from a late one, and a write that was ignored from a write that was delayed.

// File: rtl/slot_strobe_pkg.sv
package slot_strobe_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_STROBE  = 2'd1,
    SEQ_RECOVER = 2'd2
  } seq_state_e;

endpackage

// File: rtl/slot_timing_regs.sv
module slot_timing_regs #(
  parameter int NUM_SLOTS = 4,
  parameter int CODE_W    = 2,
  localparam int FIELD_W  = 2 * CODE_W,
  localparam int REG_W    = NUM_SLOTS * FIELD_W,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              idle_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [CODE_W-1:0] dur_code_o,
  output logic [CODE_W-1:0] rec_code_o
);

  logic [REG_W-1:0]  timing_q;
  logic [CODE_W-1:0] dur_field [NUM_SLOTS];
  logic [CODE_W-1:0] rec_field [NUM_SLOTS];

  // writes land only between accesses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                timing_q <= '0;
    else if (wr_en_i && idle_i) timing_q <= wr_data_i;
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_field
    assign dur_field[g] = timing_q[g*FIELD_W+CODE_W +: CODE_W];
    assign rec_field[g] = timing_q[g*FIELD_W        +: CODE_W];
  end

  assign dur_code_o = dur_field[slot_i];
  assign rec_code_o = rec_field[slot_i];

endmodule

// File: rtl/slot_tick_decode.sv
module slot_tick_decode #(
  parameter int CODE_W = 2,
  parameter int CNT_W  = 4,
  localparam int NUM_CODES = 1 << CODE_W,
  parameter logic [NUM_CODES*CNT_W-1:0] TICK_TABLE = {4'd15, 4'd12, 4'd4, 4'd3}
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  ticks_o
);

  assign ticks_o = TICK_TABLE[int'(code_i)*CNT_W +: CNT_W];

endmodule

// File: rtl/slot_access_seq.sv
module slot_access_seq
  import slot_strobe_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int CNT_W     = 4,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [SLOT_W-1:0] req_slot_i,
  input  logic              req_we_i,
  input  logic [CNT_W-1:0]  dur_ticks_i,
  input  logic [CNT_W-1:0]  rec_ticks_i,
  output seq_state_e        state_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              we_o,
  output logic              capture_o,
  output logic              done_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  rec_q;
  logic [SLOT_W-1:0] slot_q;
  logic              we_q;
  logic              done_q;
  logic              last_tick;

  assign last_tick = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      rec_q   <= '0;
      slot_q  <= '0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (req_i) begin
            state_q <= SEQ_STROBE;
            cnt_q   <= dur_ticks_i - ONE;
            rec_q   <= rec_ticks_i;
            slot_q  <= req_slot_i;
            we_q    <= req_we_i;
          end
        end
        SEQ_STROBE: begin
          if (last_tick) begin
            state_q <= SEQ_RECOVER;
            cnt_q   <= rec_q - ONE;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        SEQ_RECOVER: begin
          if (last_tick) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign state_o   = state_q;
  assign slot_o    = slot_q;
  assign we_o      = we_q;
  assign capture_o = (state_q == SEQ_STROBE) && last_tick;
  assign done_o    = done_q;

endmodule

// File: rtl/slot_strobe_gen.sv
module slot_strobe_gen
  import slot_strobe_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int CODE_W    = 2,
  parameter int CNT_W     = 4,
  parameter int DATA_W    = 8,
  localparam int NUM_CODES = 1 << CODE_W,
  parameter logic [NUM_CODES*CNT_W-1:0] TICK_TABLE = {4'd15, 4'd12, 4'd4, 4'd3},
  localparam int REG_W    = NUM_SLOTS * 2 * CODE_W,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  input  logic              req_i,
  input  logic [SLOT_W-1:0] req_slot_i,
  input  logic              req_we_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [NUM_SLOTS-1:0] strobe_o,
  output logic              strobe_we_o,
  output logic [DATA_W-1:0] rd_data_o
);

  seq_state_e        state;
  logic [SLOT_W-1:0] act_slot;
  logic              act_we;
  logic              capture;
  logic              idle;
  logic [CODE_W-1:0] dur_code, rec_code;
  logic [CNT_W-1:0]  dur_ticks, rec_ticks;
  logic [DATA_W-1:0] rd_q;

  assign idle = (state == SEQ_IDLE);

  slot_timing_regs #(
    .NUM_SLOTS(NUM_SLOTS),
    .CODE_W   (CODE_W)
  ) regs_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cfg_we_i),
    .wr_data_i (cfg_wdata_i),
    .idle_i    (idle),
    .slot_i    (req_slot_i),
    .dur_code_o(dur_code),
    .rec_code_o(rec_code)
  );

  slot_tick_decode #(
    .CODE_W    (CODE_W),
    .CNT_W     (CNT_W),
    .TICK_TABLE(TICK_TABLE)
  ) dur_dec_i (
    .code_i (dur_code),
    .ticks_o(dur_ticks)
  );

  slot_tick_decode #(
    .CODE_W    (CODE_W),
    .CNT_W     (CNT_W),
    .TICK_TABLE(TICK_TABLE)
  ) rec_dec_i (
    .code_i (rec_code),
    .ticks_o(rec_ticks)
  );

  slot_access_seq #(
    .NUM_SLOTS(NUM_SLOTS),
    .CNT_W    (CNT_W)
  ) seq_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .req_slot_i (req_slot_i),
    .req_we_i   (req_we_i),
    .dur_ticks_i(dur_ticks),
    .rec_ticks_i(rec_ticks),
    .state_o    (state),
    .slot_o     (act_slot),
    .we_o       (act_we),
    .capture_o  (capture),
    .done_o     (done_o)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_strobe
    assign strobe_o[g] = (state == SEQ_STROBE) && (act_slot == SLOT_W'(g));
  end

  assign strobe_we_o = (state == SEQ_STROBE) && act_we;
  assign busy_o      = !idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rd_q <= '0;
    else if (capture && !act_we) rd_q <= rd_data_i;
  end

  assign rd_data_o = rd_q;

endmodule

// File: rtl/slot_strobe_chk.sv
module slot_strobe_chk #(
  parameter int NUM_SLOTS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 busy_o,
  input logic                 done_o,
  input logic [NUM_SLOTS-1:0] strobe_o
);

  assert_strobe_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobe_o));

  assert_strobe_starts_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (strobe_o != '0));

  assert_strobe_in_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o != '0) |-> busy_o);

  assert_recovery_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|strobe_o) |-> busy_o);

  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_end_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_slot_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o != '0) |=> (strobe_o == '0 || strobe_o == $past(strobe_o)));

endmodule

bind slot_strobe_gen slot_strobe_chk #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .strobe_o(strobe_o)
);

// File: tb/slot_strobe_gen_tb_top.sv
module slot_strobe_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        req = 1'b0;
  logic [1:0]  req_slot = '0;
  logic        req_we = 1'b0;
  logic [7:0]  rd_data_in = '0;
  logic        busy, done, strobe_we;
  logic [3:0]  strobe;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] last_rd = '0;

  always #10 clk = ~clk;

  slot_strobe_gen dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_we_i   (cfg_we),
    .cfg_wdata_i(cfg_wdata),
    .req_i      (req),
    .req_slot_i (req_slot),
    .req_we_i   (req_we),
    .rd_data_i  (rd_data_in),
    .busy_o     (busy),
    .done_o     (done),
    .strobe_o   (strobe),
    .strobe_we_o(strobe_we),
    .rd_data_o  (rd_data)
  );

  // {timing word, slot, write flag}
  localparam logic [18:0] VEC [8] = '{
    {16'hB1E4, 2'd0, 1'b0},
    {16'hB1E4, 2'd1, 1'b1},
    {16'hB1E4, 2'd2, 1'b0},
    {16'hB1E4, 2'd3, 1'b1},
    {16'h4E1B, 2'd0, 1'b0},
    {16'h4E1B, 2'd1, 1'b1},
    {16'h4E1B, 2'd2, 1'b0},
    {16'h4E1B, 2'd3, 1'b0}
  };

  function automatic int ticks(input logic [1:0] code);
    case (code)
      2'b00:   return 3;
      2'b01:   return 4;
      2'b10:   return 12;
      default: return 15;
    endcase
  endfunction

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic write_cfg(input logic [15:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // call at a negedge; returns at the negedge of the done cycle
  task automatic run_access(input logic [1:0] slot, input bit we, input int exp_dur, input int exp_rec);
    int scnt = 0, rcnt = 0, guard = 0;
    bit slot_ok = 1'b1, we_ok = 1'b1, first_busy;
    req = 1'b1; req_slot = slot; req_we = we;
    @(negedge clk);
    req = 1'b0;
    first_busy = busy;
    while (!done && guard < 64) begin
      if (strobe != 4'b0) begin
        if (strobe != (4'b1 << slot)) slot_ok = 1'b0;
        if (strobe_we != we) we_ok = 1'b0;
        if (rcnt != 0) slot_ok = 1'b0;
        scnt++;
        rd_data_in = 8'(scnt);
      end else if (busy) begin
        rcnt++;
      end
      guard++;
      @(negedge clk);
    end
    check(first_busy, "R7 busy after accept", int'(first_busy), 1);
    check(slot_ok, "R4 strobe slot", int'(strobe), 1 << slot);
    check(we_ok, "R4 strobe write flag", int'(!we_ok), 0);
    check(scnt == exp_dur, "R4 R1 R2 duration", scnt, exp_dur);
    check(rcnt == exp_rec, "R5 R1 R2 recovery", rcnt, exp_rec);
    check(done && !busy, "R6 done with busy low", int'(done), 1);
    if (!we) begin
      check(rd_data == 8'(exp_dur), "R9 read capture on last strobe clock", rd_data, exp_dur);
      last_rd = rd_data;
    end else begin
      check(rd_data == last_rd, "R9 write leaves read data", rd_data, last_rd);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic [3:0]  fld;
    int hit;
    repeat (3) @(negedge clk);
    // R3 reset state
    check(strobe == 0 && !busy && !done && rd_data == 0, "R3 outputs at reset",
          {strobe, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(strobe == 0 && !busy && !done && rd_data == 0, "R3 outputs idle after reset",
          {strobe, busy, done}, 0);
    run_access(2'd2, 1'b0, 3, 3);  // R3 default timing
    @(negedge clk);
    check(!done && !busy, "R6 done lasts one cycle", int'(done), 0);

    // table walk
    for (int i = 0; i < 8; i++) begin
      w   = VEC[i][18:3];
      fld = w[VEC[i][2:1]*4 +: 4];
      write_cfg(w);
      run_access(VEC[i][2:1], VEC[i][0], ticks(fld[3:2]), ticks(fld[1:0]));
      @(negedge clk);
    end

    // R10: write while busy ignored, write while idle applied
    write_cfg(16'h0000);
    req = 1'b1; req_slot = 2'd1; req_we = 1'b1;
    @(negedge clk);
    req = 1'b0; cfg_we = 1'b1; cfg_wdata = 16'hFFFF;
    @(negedge clk);
    cfg_we = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    run_access(2'd1, 1'b1, 3, 3);  // R10 busy write ignored
    @(negedge clk);
    write_cfg(16'hFFFF);
    run_access(2'd1, 1'b1, 15, 15);  // R10 idle write applied

    // R6 back to back: request in the done cycle
    run_access(2'd0, 1'b0, 15, 15);

    // R8: request held during busy is dropped
    @(negedge clk);
    req = 1'b1; req_slot = 2'd0; req_we = 1'b1;
    @(negedge clk);
    req_slot = 2'd3;
    repeat (5) @(negedge clk);
    req = 1'b0;
    hit = 0;
    while (!done) begin
      if (strobe[3]) hit++;
      @(negedge clk);
    end
    repeat (20) begin
      @(negedge clk);
      if (strobe != 0 || busy) hit++;
    end
    check(hit == 0, "R8 request during busy dropped", hit, 0);

    report();
    $finish;
  end

endmodule